// File: doc/BRIEF.md
# Idle-Mode Clock Divider Controller

This block sequences a processor core through its low-power states. From normal running it accepts an idle request. The request either halts instruction issue while keeping the clock at full rate (plain idle) or also thins the clock enables by a selectable ratio (slow idle). It also accepts a power-down request. While idle, the block watches a vector of interrupt requests and their enables. An interrupt that is both pending and enabled brings the core back to full speed. The block then raises a one-cycle resume strobe, so the interrupt is serviced and issue continues after the idle instruction.

In slow idle, a free-running period counter produces a one-cycle enable every n full-rate cycles. The counter starts from zero when slow idle is entered. The core enable and every peripheral enable (serial clock, clock output, timer tick) follow that pulse. A wake waits for the end of the current divided period, so its latency is at most n full-rate cycles. DMA-style cycle-steal requests are still granted in both idle states. Power-down stops all enables and raises an acknowledge, and only reset leaves it.

Top module: `idle_clk_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, the block is running: `pm_state`=0, `issue_en`=1, `core_ce`=1, all `periph_ce` bits 1, `resume`=0, `pdown_ack`=0.
- R2: When running, `idle_req`=1 with `idle_slow`=0 enters plain idle on the next cycle. In plain idle, `issue_en`=0 and `core_ce` and `periph_ce` stay 1 on every cycle.
- R3: In plain idle, an unmasked interrupt (any bit with `irq_req` and `irq_en` both 1) seen at a clock edge returns the block to running in the next cycle.
- R4: When running, `idle_req`=1 with `idle_slow`=1 enters slow idle with divisor n = 16 << `idle_div` (code 0→16, 1→32, 2→64, 3→128). The code is captured at entry.
- R5: In slow idle, numbering the cycles from 0 after entry, `core_ce` and every `periph_ce` bit are 1 exactly in cycles n-1, 2n-1, 3n-1, … and 0 in all other cycles.
- R6: In slow idle, an unmasked interrupt seen at an edge, even for one cycle only, is remembered. The block returns to running after the edge that ends the next cycle with `core_ce`=1. If the interrupt was seen at the cycle whose index mod n is c, the latency to running is n-c cycles, never more than n.
- R7: Every return from an idle state to running raises `resume` for exactly the first running cycle.
- R8: Interrupts with `irq_en`=0 are ignored in both idle states and cause no wake.
- R9: `steal_gnt` follows `steal_req` in the running and both idle states, and is 0 in power-down.
- R10: When running, `pdown_req`=1 enters power-down on the next cycle: `pdown_ack`=1, `core_ce`=0, `periph_ce`=0, `issue_en`=0. Interrupts and idle requests are ignored there, and only reset returns to running.
- R11: If `pdown_req` and `idle_req` are both 1 in the same running cycle, power-down is entered.
- R12: `pm_state` encodes the state: 0 running, 1 plain idle, 2 slow idle, 3 power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req | input | 1 | Idle request strobe from the issue stage |
| idle_slow | input | 1 | 1 selects slow idle, 0 plain idle |
| idle_div | input | 2 | Divisor code, n = 16 << code |
| pdown_req | input | 1 | Power-down request |
| irq_req | input | 4 | Pending interrupt lines |
| irq_en | input | 4 | Per-line interrupt enable (1 = unmasked) |
| steal_req | input | 1 | DMA / autobuffer cycle-steal request |
| steal_gnt | output | 1 | Cycle-steal grant |
| issue_en | output | 1 | Instruction issue allowed |
| resume | output | 1 | One-cycle wake strobe |
| core_ce | output | 1 | Core clock enable |
| periph_ce | output | 3 | Serial clock, clock output and timer enables |
| pdown_ack | output | 1 | Power-down acknowledge |
| pm_state | output | 2 | Current state code |

## Verification
Slow idle is entered with each of the four divisor codes. The wake interrupt is placed at a different phase of the divided period each time: at the last cycle of a period, at the first cycle, and at mid-period points after one or more whole periods. This separates a correct wait for the period boundary from an immediate wake or a late wake. The enable pulses before each wake are counted to show that the counter restarts at entry. Interrupts held with their enable off in both idle states show that masking is honoured. A power-down request paired with an idle request, and interrupts sent during power-down, show the priority and that only reset leaves power-down.

// File: rtl/idle_pkg.sv
// Shared types for the idle-mode clock controller.
// Assumes: two-bit state code is exported on the block's status output.
package idle_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_IDLE  = 2'b01,
        ST_SLOW  = 2'b10,
        ST_PDOWN = 2'b11
    } pm_state_t;
endpackage

// File: rtl/idle_div_cnt.sv
// Period counter for slow idle. Captures the divisor code on load,
// clears to zero and then counts modulo n = 2**(BASE_LOG2+code).
// Assumes: load and active are never high in the same cycle.
module idle_div_cnt #(
    parameter int BASE_LOG2 = 4,
    parameter int CODE_W    = 2,
    localparam int CNT_W    = BASE_LOG2 + (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic              active,
    output logic              tick,
    output logic [CNT_W-1:0]  lim
);
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt;

    // capture divisor code at slow-idle entry
    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= '0;
        else if (load) code_q <= code_in;
    end

    // terminal count n-1 for the captured code
    always_comb begin
        lim = CNT_W'((1 << (BASE_LOG2 + int'(code_q))) - 1);
    end

    // free-running modulo-n counter, cleared at entry
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= '0;
        else if (active) cnt <= (cnt == lim) ? '0 : cnt + CNT_W'(1);
    end

    // one-cycle divided enable
    always_comb begin
        tick = active && (cnt == lim);
    end

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= lim));
endmodule

// File: rtl/idle_fsm.sv
// State sequencer: run, plain idle, slow idle, power-down.
// Remembers an unmasked interrupt seen in slow idle and leaves on the
// next divided tick; raises a registered one-cycle resume strobe.
// Assumes: wake is the OR of enabled pending interrupts.
module idle_fsm #(
    parameter int CNT_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idle_req,
    input  logic                idle_slow,
    input  logic                pdown_req,
    input  logic                wake,
    input  logic                tick,
    input  logic [CNT_W-1:0]    lim,
    output idle_pkg::pm_state_t state,
    output logic                enter_slow,
    output logic                resume
);
    import idle_pkg::*;

    pm_state_t        nxt;
    logic             pend;
    logic             leave;
    logic [CNT_W:0]   age;

    // entry into slow idle starts the period counter
    always_comb begin
        enter_slow = (state == ST_RUN) && !pdown_req && idle_req && idle_slow;
    end

    // wake decision for either idle state
    always_comb begin
        leave = ((state == ST_IDLE) && wake) ||
                ((state == ST_SLOW) && tick && (pend || wake));
    end

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (pdown_req)     nxt = ST_PDOWN;
                else if (idle_req) nxt = idle_slow ? ST_SLOW : ST_IDLE;
            end
            ST_IDLE:  if (leave) nxt = ST_RUN;
            ST_SLOW:  if (leave) nxt = ST_RUN;
            ST_PDOWN: nxt = ST_PDOWN;
            default:  nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // pending-wake latch for slow idle
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend <= 1'b0;
        else if (state != ST_SLOW)  pend <= 1'b0;
        else                        pend <= pend | wake;
    end

    // resume strobe
    always_ff @(posedge clk) begin
        if (!rst_n) resume <= 1'b0;
        else        resume <= leave;
    end

    // cycles spent waiting on a remembered wake (checker support)
    always_ff @(posedge clk) begin
        if (!rst_n)                age <= '0;
        else if (state != ST_SLOW) age <= '0;
        else if (pend || wake)     age <= age + (CNT_W+1)'(1);
    end

    // R6
    wake_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLOW) && (pend || wake)) |-> (age <= {1'b0, lim}));
    // R8
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !wake) |=> (state == ST_IDLE));
    // R7
    resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);
    // R10
    pdown_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDOWN) |=> (state == ST_PDOWN));
    // R11
    pdown_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && pdown_req) |=> (state == ST_PDOWN));
endmodule

// File: rtl/idle_ce_gen.sv
// Clock-enable fan-out: full rate in run and plain idle, divided tick in
// slow idle, off in power-down. One replica per peripheral enable.
// Assumes: real gating cells sit outside and consume these enables.
module idle_ce_gen #(
    parameter int NPERIPH = 3
) (
    input  idle_pkg::pm_state_t state,
    input  logic                tick,
    output logic                core_ce,
    output logic [NPERIPH-1:0]  periph_ce
);
    import idle_pkg::*;

    // core enable by state
    always_comb begin
        unique case (state)
            ST_RUN, ST_IDLE: core_ce = 1'b1;
            ST_SLOW:         core_ce = tick;
            default:         core_ce = 1'b0;
        endcase
    end

    // derived enables share the same ratio
    for (genvar g = 0; g < NPERIPH; g++) begin : g_periph
        always_comb begin
            periph_ce[g] = (state == ST_PDOWN) ? 1'b0
                         : (state == ST_SLOW)  ? tick : 1'b1;
        end
    end
endmodule

// File: rtl/idle_clk_ctrl.sv
// Top of the idle-mode clock controller: combines interrupt masking,
// the state sequencer, the period counter and the enable fan-out.
// Assumes: idle_req is a one-cycle strobe from the issue stage.
module idle_clk_ctrl #(
    parameter int NIRQ      = 4,
    parameter int NPERIPH   = 3,
    parameter int BASE_LOG2 = 4,
    parameter int CODE_W    = 2,
    localparam int CNT_W    = BASE_LOG2 + (1 << CODE_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idle_req,
    input  logic               idle_slow,
    input  logic [CODE_W-1:0]  idle_div,
    input  logic               pdown_req,
    input  logic [NIRQ-1:0]    irq_req,
    input  logic [NIRQ-1:0]    irq_en,
    input  logic               steal_req,
    output logic               steal_gnt,
    output logic               issue_en,
    output logic               resume,
    output logic               core_ce,
    output logic [NPERIPH-1:0] periph_ce,
    output logic               pdown_ack,
    output logic [1:0]         pm_state
);
    import idle_pkg::*;

    pm_state_t        state;
    logic             wake;
    logic             enter_slow;
    logic             tick;
    logic [CNT_W-1:0] lim;

    // any enabled pending interrupt
    always_comb begin
        wake = |(irq_req & irq_en);
    end

    idle_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_req   (idle_req),
        .idle_slow  (idle_slow),
        .pdown_req  (pdown_req),
        .wake       (wake),
        .tick       (tick),
        .lim        (lim),
        .state      (state),
        .enter_slow (enter_slow),
        .resume     (resume)
    );

    idle_div_cnt #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (enter_slow),
        .code_in (idle_div),
        .active  (state == ST_SLOW),
        .tick    (tick),
        .lim     (lim)
    );

    idle_ce_gen #(.NPERIPH(NPERIPH)) u_ce (
        .state     (state),
        .tick      (tick),
        .core_ce   (core_ce),
        .periph_ce (periph_ce)
    );

    // status, issue, steal grant and acknowledge decode
    always_comb begin
        pm_state  = state;
        issue_en  = (state == ST_RUN);
        pdown_ack = (state == ST_PDOWN);
        steal_gnt = steal_req && (state != ST_PDOWN);
    end

    // R10
    pdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdown_ack |-> (!core_ce && (periph_ce == '0) && !issue_en));
endmodule

// File: tb/tb_idle_clk_ctrl.sv
module tb_idle_clk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_req = 1'b0, idle_slow = 1'b0, pdown_req = 1'b0, steal_req = 1'b0;
    logic [1:0] idle_div = 2'd0;
    logic [3:0] irq_req = 4'd0, irq_en = 4'd0;
    logic       steal_gnt, issue_en, resume, core_ce, pdown_ack;
    logic [2:0] periph_ce;
    logic [1:0] pm_state;

    int total = 0;
    int bad = 0;

    // reference model state
    int m_st = 0, m_cnt = 0, m_n = 16, m_res = 0, m_pend = 0;

    always #5 clk = ~clk;

    idle_clk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_slow(idle_slow),
        .idle_div(idle_div), .pdown_req(pdown_req), .irq_req(irq_req),
        .irq_en(irq_en), .steal_req(steal_req), .steal_gnt(steal_gnt),
        .issue_en(issue_en), .resume(resume), .core_ce(core_ce),
        .periph_ce(periph_ce), .pdown_ack(pdown_ack), .pm_state(pm_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model step, one per clock edge
    always @(posedge clk) begin
        int unm;
        unm = ((irq_req & irq_en) != 0) ? 1 : 0;
        m_res = 0;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pend = 0;
        end else begin
            case (m_st)
                0: if (pdown_req) m_st = 3;
                   else if (idle_req) begin
                       if (idle_slow) begin
                           m_st = 2; m_n = 16 << idle_div; m_cnt = 0; m_pend = 0;
                       end else m_st = 1;
                   end
                1: if (unm != 0) begin m_st = 0; m_res = 1; end
                2: begin
                       if (m_cnt == m_n - 1 && (m_pend != 0 || unm != 0)) begin
                           m_st = 0; m_res = 1;
                       end else begin
                           m_pend = m_pend | unm;
                           m_cnt = (m_cnt + 1) % m_n;
                       end
                   end
                default: m_st = 3;
            endcase
        end
    end

    // compare all outputs every cycle, shortly after the edge
    always @(posedge clk) begin
        int ece;
        #2;
        if (rst_n) begin
            ece = (m_st == 0 || m_st == 1) ? 1 : (m_st == 2) ? int'(m_cnt == m_n - 1) : 0;
            chk("R12 pm_state", pm_state, m_st);
            chk("R2 issue_en", issue_en, int'(m_st == 0));
            chk("R5 core_ce", core_ce, ece);
            chk("R5 periph_ce", periph_ce, ece * 7);
            chk("R7 resume", resume, m_res);
            chk("R9 steal_gnt", steal_gnt, int'(steal_req && m_st != 3));
            chk("R10 pdown_ack", pdown_ack, int'(m_st == 3));
        end
    end

    // slow-idle wake: wait k cycles, one-cycle unmasked interrupt, measure latency
    task automatic slow_wake(input int code, input int k, input bit masked_wait);
        int n, lat, pulses, c;
        n = 16 << code;
        @(negedge clk); idle_req = 1; idle_slow = 1; idle_div = 2'(code);
        @(negedge clk); idle_req = 0; idle_div = 2'(3 - code);
        chk("R4 slow entry", pm_state, 2);
        pulses = 0;
        if (masked_wait) begin irq_req = 4'hF; irq_en = 4'h0; end
        for (int i = 0; i < k; i++) begin
            pulses += int'(core_ce);
            @(negedge clk);
        end
        if (masked_wait) chk("R8 masked in slow idle", pm_state, 2);
        chk("R5 pulses before wake", pulses, k / n);
        irq_req = 4'b0100; irq_en = 4'b0100;
        @(negedge clk); irq_req = 0; irq_en = 0;
        lat = 1;
        while (pm_state != 2'd0 && lat <= 300) begin
            @(negedge clk); lat++;
        end
        c = k % n;
        chk("R6 wake latency", lat, n - c);
        chk("R6 latency bound", int'(lat <= n), 1);
        chk("R7 resume at wake", resume, 1);
        @(negedge clk);
        chk("R7 resume single", resume, 0);
    endtask

    initial begin
        #1_500_000;
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", pm_state, 0);
        chk("R1 issue_en", issue_en, 1);
        chk("R1 core_ce", core_ce, 1);
        chk("R1 periph_ce", periph_ce, 7);
        chk("R1 resume", resume, 0);
        chk("R1 pdown_ack", pdown_ack, 0);

        // interrupt while running changes nothing
        irq_req = 4'h1; irq_en = 4'h1;
        @(negedge clk); irq_req = 0; irq_en = 0;
        chk("R3 no effect in run", resume, 0);

        // plain idle: R2, R8, R9, R3
        idle_req = 1; idle_slow = 0;
        @(negedge clk); idle_req = 0;
        chk("R2 plain idle state", pm_state, 1);
        chk("R2 issue off", issue_en, 0);
        chk("R2 full-rate ce", core_ce, 1);
        irq_req = 4'hA; irq_en = 4'h5; steal_req = 1;
        repeat (5) @(negedge clk);
        chk("R8 masked in plain idle", pm_state, 1);
        chk("R9 steal in idle", steal_gnt, 1);
        steal_req = 0; irq_en = 4'h2;
        @(negedge clk); irq_req = 0; irq_en = 0;
        chk("R3 wake to run", pm_state, 0);
        chk("R7 resume high", resume, 1);
        @(negedge clk);
        chk("R7 resume low", resume, 0);

        // slow idle, all four divisors at different phases
        slow_wake(0, 40, 0);
        slow_wake(1, 31, 0);
        slow_wake(2, 0, 0);
        slow_wake(3, 200, 1);

        // power-down priority and exit
        @(negedge clk); pdown_req = 1; idle_req = 1; idle_slow = 1;
        @(negedge clk); pdown_req = 0; idle_req = 0;
        chk("R11 pdown wins", pm_state, 3);
        chk("R10 ack", pdown_ack, 1);
        chk("R10 ce off", core_ce, 0);
        irq_req = 4'hF; irq_en = 4'hF; idle_req = 1; steal_req = 1;
        repeat (4) @(negedge clk);
        chk("R10 stays down", pm_state, 3);
        chk("R9 no steal in pdown", steal_gnt, 0);
        irq_req = 0; irq_en = 0; idle_req = 0; steal_req = 0;
        rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R10 reset exits", pm_state, 0);
        chk("R10 ack cleared", pdown_ack, 0);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule